// File: doc/BRIEF.md
# Typewriter Console Attachment Controller

This block is the control state machine between an I/O channel and a typewriter-style console. The console has a keyboard, a printer and a card punch. The channel issues one command per cycle: keyboard read, write, reader read, test or halt. Each command gets a one-cycle response one clock later. The response carries a condition code and a status byte. The block runs one operation at a time and tracks its completion events from the console. It collects the ending status into a pending status byte and raises an interrupt while that byte is non-zero. It also drives the keyboard lock, the proceed light and a carrier-return/line-feed request.

A halt ends an operation in a way that depends on the operation. A keyboard entry or a write ends on the spot. A halted reader read gives channel-end at once but stays busy until end of media, and only then gives device-end. Attention requests that arrive while an operation runs are held until the block is idle again.

While a write is active, punch characters pass through a valid/ready stream. A character is taken only in a cycle where both valid and ready are high. The upstream source must hold the character and valid steady until it is taken. The output side holds each character until it is taken. Three cases release the current card: an end-of-block character, an end-of-transmission character, or a prefix character followed by the H character. While the card is released and the next one is registered, ready stays low. Character translation and the device mechanics are outside this block.

Top module: `console_ctl`

## Requirements
- R1: When power_ok is low, connect_on is low or ce_mode is high, every command gets resp_cc 3 with resp_csw 0 and changes nothing else.
- R2: A start command that is accepted gets resp_cc 0 and resp_csw 0, one cycle after cmd_valid. The start codes are 1 for keyboard read, 2 for write and 3 for reader read. A keyboard read also unlocks the keyboard (kbd_lock low) and lights proceed_light.
- R3: Status byte bits are: bit 7 attention, bit 4 busy (response only), bit 3 channel-end, bit 2 device-end and bit 1 unit-check. Normal completion posts channel-end and device-end (0x0C). Keyboard read completes on kbd_done, write on wr_done and reader read on rdr_eom. A keyboard read completion also relocks the keyboard and turns the light off.
- R4: In two cases a start gets resp_cc 1 with resp_csw equal to the pending status OR 0x10, and the current operation does not change: an operation is already running, or status is still pending. Command codes 0, 6 and 7 get resp_cc 1 with resp_csw 0x02 (command reject).
- R5: A halt (code 5) during a keyboard read ends it at once. It locks the keyboard, turns the light off, posts 0x0C and pulses crlf_req for one cycle.
- R6: A halt during a write ends it at once. It posts 0x0C and pulses crlf_req.
- R7: A halt during a reader read posts channel-end only (0x08) and pulses crlf_req. The unit stays busy until rdr_eom arrives, which then posts device-end (0x04).
- R8: Every halt clears chain_active. chain_active takes the value of cmd_chain when a start is accepted. A halt always gets resp_cc 0.
- R9: A test (code 4) behaves as follows. While an operation runs it gets resp_cc 1 with pending status OR 0x10. When idle with status pending it gets resp_cc 1 with that status. When idle with nothing pending it gets resp_cc 0 and resp_csw 0. A test clears the pending status.
- R10: attn_req while idle posts attention (0x80). While an operation runs the request is held, and it is posted in the cycle after the block returns to idle.
- R11: irq is high exactly while the status byte is non-zero. stat_accept clears the status byte.
- R12: The punch stream is ready only during a write. Characters other than release and prefix characters come out in order. The release characters are EOB, EOT, and PFX followed by HCH. They are not forwarded, and each gives a one-cycle card_release pulse. A PFX followed by any other character forwards only that character.
- R13: From a card release until card_fed is seen, pch_in_ready stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cmd_valid | input | 1 | Command strobe, one cycle |
| cmd_code | input | 3 | Command code |
| cmd_chain | input | 1 | Chaining flag given with a start command |
| resp_valid | output | 1 | Response strobe, one cycle after cmd_valid |
| resp_cc | output | 2 | Condition code |
| resp_csw | output | 8 | Status stored for the command |
| power_ok | input | 1 | Console power is on |
| connect_on | input | 1 | CPU connect switch is on |
| ce_mode | input | 1 | Maintenance mode |
| kbd_done | input | 1 | Operator ended keyboard entry |
| wr_done | input | 1 | Write finished |
| rdr_eom | input | 1 | Reader reached end of media |
| attn_req | input | 1 | Attention request pulse |
| stat_accept | input | 1 | Channel takes the pending status |
| stat_byte | output | 8 | Pending status byte |
| irq | output | 1 | Interrupt condition |
| kbd_lock | output | 1 | Keyboard locked |
| proceed_light | output | 1 | Proceed indicator |
| crlf_req | output | 1 | Carrier-return/line-feed request pulse |
| chain_active | output | 1 | Chaining flag of the current operation |
| pch_in_valid | input | 1 | Punch character valid |
| pch_in_ready | output | 1 | Punch character ready |
| pch_in_data | input | 8 | Punch character |
| pch_out_valid | output | 1 | Character to punch valid |
| pch_out_ready | input | 1 | Punch takes the character |
| pch_out_data | output | 8 | Character to punch |
| card_release | output | 1 | Release current card, one-cycle pulse |
| card_fed | input | 1 | Next card registered |

## Verification
A wrong operation state shows at the ports one cycle after the next command. A start or a test then returns the wrong condition code or a stray busy bit. A missed completion leaves irq low where it should rise. A release latch that is stuck, or cleared too early, shows on pch_in_ready in the very next cycle after card_release or card_fed. A lost held attention shows as a missing 0x80 one cycle after the operation ends.

// File: rtl/console_pkg.sv
package console_pkg;
  typedef enum logic [2:0] {
    OP_IDLE  = 3'd0,
    OP_KBD   = 3'd1,
    OP_WRITE = 3'd2,
    OP_READ  = 3'd3,
    OP_DRAIN = 3'd4
  } op_e;

  localparam logic [2:0] C_KBD   = 3'd1;
  localparam logic [2:0] C_WRITE = 3'd2;
  localparam logic [2:0] C_READ  = 3'd3;
  localparam logic [2:0] C_TEST  = 3'd4;
  localparam logic [2:0] C_HALT  = 3'd5;

  localparam int SB_ATTN = 7;
  localparam int SB_BUSY = 4;
  localparam int SB_CE   = 3;
  localparam int SB_DE   = 2;
  localparam int SB_UC   = 1;
endpackage

// File: rtl/console_status.sv
module console_status #(
  parameter int SW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [SW-1:0] post,
  input  logic          clear,
  input  logic          attn_req,
  input  logic          attn_ok,
  output logic [SW-1:0] stat_q,
  output logic          pending
);
  import console_pkg::*;

  logic          held_q;
  logic          attn_post;
  logic [SW-1:0] attn_vec;

  assign attn_post = attn_ok && (attn_req || held_q);
  assign attn_vec  = attn_post ? (SW'(1) << SB_ATTN) : '0;
  assign pending   = |stat_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_q <= '0;
      held_q <= 1'b0;
    end else begin
      stat_q <= (clear ? '0 : stat_q) | post | attn_vec;
      held_q <= !attn_ok && (held_q || attn_req);
    end
  end
endmodule

// File: rtl/console_punch.sv
module console_punch #(
  parameter int          DW  = 8,
  parameter logic [DW-1:0] EOB = 8'h26,
  parameter logic [DW-1:0] EOT = 8'h37,
  parameter logic [DW-1:0] PFX = 8'h24,
  parameter logic [DW-1:0] HCH = 8'hC8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          enable,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [DW-1:0] in_data,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [DW-1:0] out_data,
  output logic          card_release,
  input  logic          card_fed
);
  logic releasing_q, pfx_q, rel_q, ov_q;
  logic [DW-1:0] od_q;
  logic take, is_end;

  assign in_ready     = enable && !releasing_q && (!ov_q || out_ready);
  assign take         = in_valid && in_ready;
  assign is_end       = (in_data == EOB) || (in_data == EOT) || (pfx_q && in_data == HCH);
  assign out_valid    = ov_q;
  assign out_data     = od_q;
  assign card_release = rel_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      releasing_q <= 1'b0;
      pfx_q       <= 1'b0;
      rel_q       <= 1'b0;
      ov_q        <= 1'b0;
      od_q        <= '0;
    end else begin
      rel_q <= 1'b0;
      if (ov_q && out_ready) ov_q <= 1'b0;
      if (releasing_q && card_fed) releasing_q <= 1'b0;
      if (take) begin
        if (is_end) begin
          releasing_q <= 1'b1;
          rel_q       <= 1'b1;
          pfx_q       <= 1'b0;
        end else if (in_data == PFX) begin
          pfx_q <= 1'b1;
        end else begin
          ov_q  <= 1'b1;
          od_q  <= in_data;
          pfx_q <= 1'b0;
        end
      end
    end
  end
endmodule

// File: rtl/console_ctl.sv
module console_ctl #(
  parameter int          DW  = 8,
  parameter logic [DW-1:0] EOB = 8'h26,
  parameter logic [DW-1:0] EOT = 8'h37,
  parameter logic [DW-1:0] PFX = 8'h24,
  parameter logic [DW-1:0] HCH = 8'hC8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_valid,
  input  logic [2:0]    cmd_code,
  input  logic          cmd_chain,
  output logic          resp_valid,
  output logic [1:0]    resp_cc,
  output logic [7:0]    resp_csw,
  input  logic          power_ok,
  input  logic          connect_on,
  input  logic          ce_mode,
  input  logic          kbd_done,
  input  logic          wr_done,
  input  logic          rdr_eom,
  input  logic          attn_req,
  input  logic          stat_accept,
  output logic [7:0]    stat_byte,
  output logic          irq,
  output logic          kbd_lock,
  output logic          proceed_light,
  output logic          crlf_req,
  output logic          chain_active,
  input  logic          pch_in_valid,
  output logic          pch_in_ready,
  input  logic [DW-1:0] pch_in_data,
  output logic          pch_out_valid,
  input  logic          pch_out_ready,
  output logic [DW-1:0] pch_out_data,
  output logic          card_release,
  input  logic          card_fed
);
  import console_pkg::*;

  localparam logic [7:0] ST_END  = (8'd1 << SB_CE) | (8'd1 << SB_DE);
  localparam logic [7:0] ST_CE   = 8'd1 << SB_CE;
  localparam logic [7:0] ST_DE   = 8'd1 << SB_DE;
  localparam logic [7:0] ST_BUSY = 8'd1 << SB_BUSY;
  localparam logic [7:0] ST_UC   = 8'd1 << SB_UC;

  op_e        op_q;
  logic       oper, cmd_ok, is_start, busy_any, start_go, halt, test_cmd, pending;
  logic [7:0] post;
  logic       clear;

  assign oper     = power_ok && connect_on && !ce_mode;
  assign cmd_ok   = cmd_valid && oper;
  assign is_start = (cmd_code == C_KBD) || (cmd_code == C_WRITE) || (cmd_code == C_READ);
  assign busy_any = (op_q != OP_IDLE) || pending;
  assign start_go = cmd_ok && is_start && !busy_any;
  assign halt     = cmd_ok && (cmd_code == C_HALT);
  assign test_cmd = cmd_ok && (cmd_code == C_TEST);
  assign clear    = stat_accept || test_cmd;
  assign irq      = pending;

  always_comb begin
    post = '0;
    unique case (op_q)
      OP_KBD:   if (kbd_done || halt) post = ST_END;
      OP_WRITE: if (wr_done || halt) post = ST_END;
      OP_READ:  if (rdr_eom) post = ST_END; else if (halt) post = ST_CE;
      OP_DRAIN: if (rdr_eom) post = ST_DE;
      default:  post = '0;
    endcase
  end

  console_status #(.SW(8)) u_status (
    .clk(clk), .rst_n(rst_n), .post(post), .clear(clear),
    .attn_req(attn_req), .attn_ok((op_q == OP_IDLE) && !start_go),
    .stat_q(stat_byte), .pending(pending)
  );

  console_punch #(.DW(DW), .EOB(EOB), .EOT(EOT), .PFX(PFX), .HCH(HCH)) u_punch (
    .clk(clk), .rst_n(rst_n), .enable(op_q == OP_WRITE),
    .in_valid(pch_in_valid), .in_ready(pch_in_ready), .in_data(pch_in_data),
    .out_valid(pch_out_valid), .out_ready(pch_out_ready), .out_data(pch_out_data),
    .card_release(card_release), .card_fed(card_fed)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      resp_valid <= 1'b0;
      resp_cc    <= 2'd0;
      resp_csw   <= 8'd0;
    end else begin
      resp_valid <= cmd_valid;
      resp_cc    <= 2'd0;
      resp_csw   <= 8'd0;
      if (cmd_valid) begin
        if (!oper) begin
          resp_cc <= 2'd3;
        end else if (is_start) begin
          if (busy_any) begin
            resp_cc  <= 2'd1;
            resp_csw <= stat_byte | ST_BUSY;
          end
        end else if (cmd_code == C_TEST) begin
          if (op_q != OP_IDLE) begin
            resp_cc  <= 2'd1;
            resp_csw <= stat_byte | ST_BUSY;
          end else if (pending) begin
            resp_cc  <= 2'd1;
            resp_csw <= stat_byte;
          end
        end else if (cmd_code != C_HALT) begin
          resp_cc  <= 2'd1;
          resp_csw <= ST_UC;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_q          <= OP_IDLE;
      kbd_lock      <= 1'b1;
      proceed_light <= 1'b0;
      crlf_req      <= 1'b0;
      chain_active  <= 1'b0;
    end else begin
      crlf_req <= 1'b0;
      if (halt) chain_active <= 1'b0;
      unique case (op_q)
        OP_IDLE: if (start_go) begin
          chain_active <= cmd_chain;
          unique case (cmd_code)
            C_KBD: begin
              op_q          <= OP_KBD;
              kbd_lock      <= 1'b0;
              proceed_light <= 1'b1;
            end
            C_WRITE: op_q <= OP_WRITE;
            default: op_q <= OP_READ;
          endcase
        end
        OP_KBD: if (kbd_done || halt) begin
          op_q          <= OP_IDLE;
          kbd_lock      <= 1'b1;
          proceed_light <= 1'b0;
          crlf_req      <= halt;
        end
        OP_WRITE: if (wr_done || halt) begin
          op_q     <= OP_IDLE;
          crlf_req <= halt;
        end
        OP_READ: begin
          if (rdr_eom) op_q <= OP_IDLE;
          else if (halt) op_q <= OP_DRAIN;
          crlf_req <= halt;
        end
        OP_DRAIN: if (rdr_eom) op_q <= OP_IDLE;
        default: op_q <= OP_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/console_ctl_chk.sv
module console_ctl_chk (
  input logic             clk,
  input logic             rst_n,
  input logic             cmd_valid,
  input logic [2:0]       cmd_code,
  input logic             power_ok,
  input logic             connect_on,
  input logic             ce_mode,
  input logic             rdr_eom,
  input logic             resp_valid,
  input logic [1:0]       resp_cc,
  input logic [7:0]       stat_byte,
  input logic             kbd_lock,
  input logic             proceed_light,
  input logic             crlf_req,
  input logic             chain_active,
  input logic             pch_in_ready,
  input logic             card_release,
  input console_pkg::op_e op_q
);
  import console_pkg::*;

  // R1
  notop_cc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && !(power_ok && connect_on && !ce_mode) |=> resp_valid && resp_cc == 2'd3);

  // R2
  light_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    proceed_light |-> !kbd_lock);

  // R5
  kbd_halt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && cmd_code == C_HALT && op_q == OP_KBD && power_ok && connect_on && !ce_mode
    |=> kbd_lock && !proceed_light && crlf_req && stat_byte[SB_CE] && stat_byte[SB_DE]);

  // R8
  halt_chain_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && cmd_code == C_HALT && power_ok && connect_on && !ce_mode |=> !chain_active);

  // R7
  drain_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    op_q == OP_DRAIN && rdr_eom |=> stat_byte[SB_DE] && op_q == OP_IDLE);

  // R10
  attn_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    op_q != OP_IDLE |-> !stat_byte[SB_ATTN]);

  // R13
  release_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    card_release |-> !pch_in_ready);
endmodule

bind console_ctl console_ctl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_code(cmd_code),
  .power_ok(power_ok), .connect_on(connect_on), .ce_mode(ce_mode), .rdr_eom(rdr_eom),
  .resp_valid(resp_valid), .resp_cc(resp_cc), .stat_byte(stat_byte),
  .kbd_lock(kbd_lock), .proceed_light(proceed_light), .crlf_req(crlf_req),
  .chain_active(chain_active), .pch_in_ready(pch_in_ready),
  .card_release(card_release), .op_q(op_q)
);

// File: tb/console_ctl_test.sv
module console_ctl_test;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cmd_valid = 0, cmd_chain = 0;
  logic [2:0] cmd_code = 0;
  logic resp_valid; logic [1:0] resp_cc; logic [7:0] resp_csw;
  logic power_ok = 1, connect_on = 1, ce_mode = 0;
  logic kbd_done = 0, wr_done = 0, rdr_eom = 0, attn_req = 0, stat_accept = 0;
  logic [7:0] stat_byte; logic irq, kbd_lock, proceed_light, crlf_req, chain_active;
  logic pch_in_valid = 0, pch_in_ready; logic [7:0] pch_in_data = 0;
  logic pch_out_valid, pch_out_ready = 1; logic [7:0] pch_out_data;
  logic card_release, card_fed = 0;

  int checks = 0, errors = 0;
  int n_out = 0, n_rel = 0;
  logic [7:0] got [0:15];
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  console_ctl uut (.*);

  always @(posedge clk) begin
    if (pch_out_valid && pch_out_ready) begin
      got[n_out[3:0]] <= pch_out_data;
      n_out <= n_out + 1;
    end
    if (card_release) n_rel <= n_rel + 1;
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic issue(input logic [2:0] code, input logic chain);
    cmd_valid = 1; cmd_code = code; cmd_chain = chain;
    @(negedge clk);
    cmd_valid = 0; cmd_chain = 0;
  endtask

  task automatic pulse(ref logic sig);
    sig = 1; @(negedge clk); sig = 0;
  endtask

  task automatic send(input logic [7:0] d);
    while (!pch_in_ready) @(negedge clk);
    pch_in_valid = 1; pch_in_data = d;
    @(negedge clk);
    pch_in_valid = 0;
  endtask

  task automatic t_reset;
    chk("R11 reset irq", irq, 0);
    chk("R2 reset lock", kbd_lock, 1);
    chk("R12 ready idle", pch_in_ready, 0);
  endtask

  task automatic t_notop;
    power_ok = 0; issue(3'd4, 0);
    chk("R1 power cc", resp_cc, 3);
    power_ok = 1; ce_mode = 1; issue(3'd1, 0);
    chk("R1 ce cc", resp_cc, 3);
    chk("R1 ce no start", proceed_light, 0);
    ce_mode = 0; connect_on = 0; issue(3'd2, 0);
    chk("R1 connect cc", resp_cc, 3);
    connect_on = 1; issue(3'd4, 0);
    chk("R9 idle test cc", resp_cc, 0);
  endtask

  task automatic t_kbd_normal;
    issue(3'd1, 0);
    chk("R2 start cc", resp_cc, 0);
    chk("R2 unlock", kbd_lock, 0);
    chk("R2 light", proceed_light, 1);
    pulse(kbd_done);
    chk("R3 end status", stat_byte, 8'h0C);
    chk("R3 relock", kbd_lock, 1);
    chk("R11 irq", irq, 1);
    issue(3'd2, 0);
    chk("R4 pending start cc", resp_cc, 1);
    chk("R4 pending start csw", resp_csw, 8'h1C);
    issue(3'd4, 0);
    chk("R9 pending test cc", resp_cc, 1);
    chk("R9 pending test csw", resp_csw, 8'h0C);
    chk("R9 test clears", stat_byte, 0);
  endtask

  task automatic t_busy;
    issue(3'd2, 0);
    issue(3'd1, 0);
    chk("R4 busy cc", resp_cc, 1);
    chk("R4 busy csw", resp_csw, 8'h10);
    chk("R4 no switch", proceed_light, 0);
    pulse(kbd_done);
    chk("R4 op kept", stat_byte, 0);
    issue(3'd4, 0);
    chk("R9 busy test", resp_csw, 8'h10);
    pulse(wr_done);
    chk("R3 write end", stat_byte, 8'h0C);
    pulse(stat_accept);
    chk("R11 accept", irq, 0);
    issue(3'd7, 0);
    chk("R4 reject cc", resp_cc, 1);
    chk("R4 reject csw", resp_csw, 8'h02);
  endtask

  task automatic t_halt_kbd;
    issue(3'd1, 1);
    chk("R8 chain set", chain_active, 1);
    issue(3'd5, 0);
    chk("R8 halt cc", resp_cc, 0);
    chk("R5 crlf", crlf_req, 1);
    chk("R5 lock", kbd_lock, 1);
    chk("R5 light", proceed_light, 0);
    chk("R5 status", stat_byte, 8'h0C);
    chk("R8 chain clear", chain_active, 0);
    @(negedge clk);
    chk("R5 crlf one cycle", crlf_req, 0);
    pulse(stat_accept);
  endtask

  task automatic t_halt_write;
    issue(3'd2, 1);
    issue(3'd5, 0);
    chk("R6 crlf", crlf_req, 1);
    chk("R6 status", stat_byte, 8'h0C);
    chk("R8 write chain", chain_active, 0);
    chk("R6 ready off", pch_in_ready, 0);
    pulse(stat_accept);
  endtask

  task automatic t_halt_read;
    issue(3'd3, 0);
    issue(3'd5, 0);
    chk("R7 ce only", stat_byte, 8'h08);
    chk("R7 crlf", crlf_req, 1);
    pulse(stat_accept);
    issue(3'd4, 0);
    chk("R7 still busy", resp_csw, 8'h10);
    issue(3'd2, 0);
    chk("R7 start refused", resp_cc, 1);
    pulse(rdr_eom);
    chk("R7 device end", stat_byte, 8'h04);
    chk("R7 second irq", irq, 1);
    pulse(stat_accept);
  endtask

  task automatic t_attn;
    pulse(attn_req);
    chk("R10 idle attn", stat_byte, 8'h80);
    pulse(stat_accept);
    issue(3'd2, 0);
    pulse(attn_req);
    chk("R10 held", stat_byte, 0);
    pulse(wr_done);
    chk("R10 end first", stat_byte, 8'h0C);
    @(negedge clk);
    chk("R10 posted", stat_byte, 8'h8C);
    pulse(stat_accept);
  endtask

  task automatic t_punch;
    issue(3'd2, 0);
    chk("R12 ready in write", pch_in_ready, 1);
    send(8'hC1); send(8'hC2); send(8'h26);
    chk("R12 eob release", card_release, 1);
    chk("R13 gate", pch_in_ready, 0);
    repeat (3) @(negedge clk);
    chk("R13 gate held", pch_in_ready, 0);
    pulse(card_fed);
    chk("R13 reopen", pch_in_ready, 1);
    send(8'hC8); send(8'h24); send(8'hC8);
    chk("R12 prefix H release", card_release, 1);
    pulse(card_fed);
    send(8'h24); send(8'hE7); send(8'h37);
    chk("R12 eot release", card_release, 1);
    pulse(card_fed);
    repeat (2) @(negedge clk);
    chk("R12 out count", n_out, 4);
    chk("R12 rel count", n_rel, 3);
    chk("R12 out0", got[0], 8'hC1);
    chk("R12 out1", got[1], 8'hC2);
    chk("R12 out2", got[2], 8'hC8);
    chk("R12 out3", got[3], 8'hE7);
    pulse(wr_done);
    pulse(stat_accept);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset; t_notop; t_kbd_normal; t_busy; t_halt_kbd;
    t_halt_write; t_halt_read; t_attn; t_punch;
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule